// File: doc/BRIEF.md
# Byte-Serial 16-bit Arithmetic Sequencer

This block carries out one 16-bit operation at a time on a datapath that is one byte wide. It handles one byte per clock and passes a carry bit from the first byte step to the second. A command is a one-cycle start strobe together with a 4-bit operation code and two 16-bit operands. The block captures them, runs two byte steps, and then presents a 16-bit result and the flags C, Z, V and N, marked by a one-cycle done pulse. The result and flags keep their values until the next command completes.

Each operation code selects four things: which byte is handled first, what value seeds the carry, whether the second operand is inverted, and whether the operands are swapped or replaced by zero. With these choices one byte adder covers addition, subtraction, increment, decrement, the equality test and the signed greater-than test. A small shifter, also one byte wide, covers the three shifts. In subtraction C holds the inverted borrow. The signed compare is the exclusive OR of the N and V flags of the reversed subtraction.

Top module: `byte_seq_alu`

## Requirements
- R1: A start strobe is accepted only when no command is in flight. A strobe raised while a command is in flight is ignored and does not change the result of the running command.
- R2: Reset clears the result, all flags and done to zero. After the accepting clock edge, result, flags and done_o are updated at the second following edge. done_o is high for exactly one cycle. Outside that cycle, result and flags hold their values.
- R3: Add (code 0) returns a+b mod 2^16. C is the carry out of bit 15. V is the carry out of bit 15 XOR the carry into bit 15.
- R4: Subtract (code 1) returns a-b mod 2^16. C=1 when no borrow occurs (a >= b unsigned). V flags signed overflow.
- R5: Increment (code 2) returns a+1 and decrement (code 3) returns a-1. Each runs as an add or subtract of zero with a seeded carry. C and V follow R3 and R4 respectively: increment gives C=1 only for a=0xFFFF, and decrement gives C=0 only for a=0x0000.
- R6: AND (code 4), OR (code 5) and XOR (code 6) work bitwise on each byte. They give C=0 and V=0.
- R7: Left shift (code 7) returns a<<1 with bit 7 moving into bit 8. C takes old bit 15, and V is old bit 15 XOR old bit 14.
- R8: Logical right shift (code 8) shifts zero into bit 15 and moves bit 8 into bit 7. C takes old bit 0, and V=0.
- R9: Arithmetic right shift (code 9) keeps bit 15 and copies it into bit 14. C takes old bit 0, and V=0.
- R10: For all codes except 10 and 11, Z=1 exactly when the result is zero, and N equals result bit 15.
- R11: Equality (code 10) returns 1 in bit 0 (other bits zero) when a equals b. C, Z, V and N are those of a-b, so bit 0 equals Z.
- R12: Signed greater-than (code 11) returns 1 in bit 0 (other bits zero) when a > b as two's complement. C, Z, V and N are those of b-a, so bit 0 equals N XOR V.
- R13: Codes 12 to 15 behave exactly as add.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command strobe |
| op_i | input | 4 | Operation code |
| a_i | input | 16 | First operand |
| b_i | input | 16 | Second operand |
| result_o | output | 16 | Result of the last completed command |
| done_o | output | 1 | One-cycle completion pulse |
| c_o | output | 1 | Carry flag (inverted borrow for subtraction) |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Two's complement overflow flag |
| n_o | output | 1 | Negative flag |

## Verification
The checker starts its own count of in-flight commands only after reset has been applied. It therefore assumes that reset is asserted before the first command. It also assumes that start_i and op_i carry known values at every clock edge, because it latches the operation code on the edge that accepts a strobe. The stimulus applies reset first and changes every input one nanosecond after a rising edge, so all values are settled when the next edge samples them. The stimulus covers directed operand corners, pseudo-random operands and codes, back-to-back commands, and strobes held high across a running command.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0,
    OP_SUB = 4'd1,
    OP_INC = 4'd2,
    OP_DEC = 4'd3,
    OP_AND = 4'd4,
    OP_OR  = 4'd5,
    OP_XOR = 4'd6,
    OP_SHL = 4'd7,
    OP_SHR = 4'd8,
    OP_SRA = 4'd9,
    OP_EQ  = 4'd10,
    OP_SGT = 4'd11
  } op_e;

  typedef enum logic [2:0] {
    K_ARITH,
    K_AND,
    K_OR,
    K_XOR,
    K_SHL,
    K_SHR
  } kind_e;

  typedef enum logic [1:0] {
    SEED_ZERO,
    SEED_ONE,
    SEED_SIGN
  } seed_e;

  typedef struct packed {
    kind_e kind;
    logic  inv_b;   // add ~b: subtraction with carry as inverted borrow
    logic  zero_b;  // second operand forced to zero (inc/dec)
    logic  swap;    // operands exchanged (b - a)
    logic  rev;     // high byte first
    seed_e seed;
    logic  use_v;
    logic  is_eq;
    logic  is_gt;
  } ctl_t;
endpackage

// File: rtl/bsa_decode.sv
module bsa_decode
  import bsa_pkg::*;
(
  input  logic [OP_W-1:0] op_i,
  output ctl_t            ctl_o
);
  timeunit 1ns;
  timeprecision 1ps;

  always_comb begin
    ctl_o.kind   = K_ARITH;
    ctl_o.inv_b  = 1'b0;
    ctl_o.zero_b = 1'b0;
    ctl_o.swap   = 1'b0;
    ctl_o.rev    = 1'b0;
    ctl_o.seed   = SEED_ZERO;
    ctl_o.use_v  = 1'b1;
    ctl_o.is_eq  = 1'b0;
    ctl_o.is_gt  = 1'b0;
    case (op_e'(op_i))
      OP_SUB: begin
        ctl_o.inv_b = 1'b1;
        ctl_o.seed  = SEED_ONE;
      end
      OP_INC: begin
        ctl_o.zero_b = 1'b1;
        ctl_o.seed   = SEED_ONE;
      end
      OP_DEC: begin
        ctl_o.zero_b = 1'b1;
        ctl_o.inv_b  = 1'b1;
      end
      OP_AND: begin
        ctl_o.kind  = K_AND;
        ctl_o.use_v = 1'b0;
      end
      OP_OR: begin
        ctl_o.kind  = K_OR;
        ctl_o.use_v = 1'b0;
      end
      OP_XOR: begin
        ctl_o.kind  = K_XOR;
        ctl_o.use_v = 1'b0;
      end
      OP_SHL: ctl_o.kind = K_SHL;
      OP_SHR: begin
        ctl_o.kind  = K_SHR;
        ctl_o.rev   = 1'b1;
        ctl_o.use_v = 1'b0;
      end
      OP_SRA: begin
        ctl_o.kind  = K_SHR;
        ctl_o.rev   = 1'b1;
        ctl_o.seed  = SEED_SIGN;
        ctl_o.use_v = 1'b0;
      end
      OP_EQ: begin
        ctl_o.inv_b = 1'b1;
        ctl_o.seed  = SEED_ONE;
        ctl_o.is_eq = 1'b1;
      end
      OP_SGT: begin
        ctl_o.inv_b = 1'b1;
        ctl_o.seed  = SEED_ONE;
        ctl_o.swap  = 1'b1;
        ctl_o.is_gt = 1'b1;
      end
      default: ;  // add and reserved codes
    endcase
  end
endmodule

// File: rtl/bsa_byte_unit.sv
module bsa_byte_unit
  import bsa_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  kind_e             kind_i,
  input  logic              inv_b_i,
  input  logic [BYTE_W-1:0] x_i,
  input  logic [BYTE_W-1:0] y_i,
  input  logic              cin_i,
  output logic [BYTE_W-1:0] q_o,
  output logic              cout_o,
  output logic              cmsb_o   // carry/bit entering the top position
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [BYTE_W-1:0] yb;
  logic [BYTE_W:0]   sum;
  logic [BYTE_W-1:0] low;

  assign yb  = inv_b_i ? ~y_i : y_i;
  assign sum = {1'b0, x_i} + {1'b0, yb} + {{BYTE_W{1'b0}}, cin_i};
  assign low = {1'b0, x_i[BYTE_W-2:0]} + {1'b0, yb[BYTE_W-2:0]}
             + {{(BYTE_W-1){1'b0}}, cin_i};

  always_comb begin
    q_o    = x_i;
    cout_o = cin_i;
    cmsb_o = cin_i;
    case (kind_i)
      K_ARITH: begin
        q_o    = sum[BYTE_W-1:0];
        cout_o = sum[BYTE_W];
        cmsb_o = low[BYTE_W-1];
      end
      K_AND: q_o = x_i & y_i;
      K_OR:  q_o = x_i | y_i;
      K_XOR: q_o = x_i ^ y_i;
      K_SHL: begin
        q_o    = {x_i[BYTE_W-2:0], cin_i};
        cout_o = x_i[BYTE_W-1];
        cmsb_o = x_i[BYTE_W-2];
      end
      K_SHR: begin
        q_o    = {cin_i, x_i[BYTE_W-1:1]};
        cout_o = x_i[0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bsa_seq.sv
module bsa_seq #(
  parameter  int NUM_STEPS = 2,
  localparam int CNT_W     = (NUM_STEPS > 1) ? $clog2(NUM_STEPS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             last_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cnt_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             busy_q, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = start_i & ~busy_q;
  assign last_o   = busy_q && (cnt_q == CNT_W'(NUM_STEPS - 1));
  assign busy_o   = busy_q;
  assign done_o   = done_q;
  assign cnt_o    = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (last_o) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/byte_seq_alu.sv
module byte_seq_alu
  import bsa_pkg::*;
#(
  parameter  int BYTE_W    = 8,
  parameter  int NUM_BYTES = 2,
  localparam int DATA_W    = BYTE_W * NUM_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              c_o,
  output logic              z_o,
  output logic              v_o,
  output logic              n_o
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CNT_W = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1;

  ctl_t              ctl_in, ctl_q;
  logic              accept, busy, last;
  logic [CNT_W-1:0]  cnt, idx;
  logic [DATA_W-1:0] opx_q, opy_q, part_q, part_next;
  logic              carry_q, zacc_q, seed_bit;
  logic [BYTE_W-1:0] x_byte, y_byte, q_byte;
  logic              cout, cmsb, zero_all, v_fin, cmp_bit;

  bsa_decode i_decode (
    .op_i (op_i),
    .ctl_o(ctl_in)
  );

  bsa_seq #(.NUM_STEPS(NUM_BYTES)) i_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .accept_o(accept),
    .busy_o  (busy),
    .last_o  (last),
    .done_o  (done_o),
    .cnt_o   (cnt)
  );

  always_comb begin
    case (ctl_in.seed)
      SEED_ONE:  seed_bit = 1'b1;
      SEED_SIGN: seed_bit = a_i[DATA_W-1];
      default:   seed_bit = 1'b0;
    endcase
  end

  assign idx    = ctl_q.rev ? (CNT_W'(NUM_BYTES - 1) - cnt) : cnt;
  assign x_byte = opx_q[int'(idx)*BYTE_W +: BYTE_W];
  assign y_byte = opy_q[int'(idx)*BYTE_W +: BYTE_W];

  bsa_byte_unit #(.BYTE_W(BYTE_W)) i_byte (
    .kind_i (ctl_q.kind),
    .inv_b_i(ctl_q.inv_b),
    .x_i    (x_byte),
    .y_i    (y_byte),
    .cin_i  (carry_q),
    .q_o    (q_byte),
    .cout_o (cout),
    .cmsb_o (cmsb)
  );

  always_comb begin
    part_next = part_q;
    part_next[int'(idx)*BYTE_W +: BYTE_W] = q_byte;
  end

  assign zero_all = zacc_q & (q_byte == '0);
  // forward ops finish on the top byte, so cout/cmsb belong to bit DATA_W-1
  assign v_fin    = ctl_q.use_v & (cout ^ cmsb);
  assign cmp_bit  = ctl_q.is_eq ? zero_all : (part_next[DATA_W-1] ^ v_fin);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q    <= '0;
      opx_q    <= '0;
      opy_q    <= '0;
      part_q   <= '0;
      carry_q  <= 1'b0;
      zacc_q   <= 1'b1;
      result_o <= '0;
      c_o      <= 1'b0;
      z_o      <= 1'b0;
      v_o      <= 1'b0;
      n_o      <= 1'b0;
    end else if (accept) begin
      ctl_q   <= ctl_in;
      opx_q   <= ctl_in.swap ? b_i : a_i;
      opy_q   <= ctl_in.zero_b ? '0 : (ctl_in.swap ? a_i : b_i);
      part_q  <= '0;
      carry_q <= seed_bit;
      zacc_q  <= 1'b1;
    end else if (busy) begin
      part_q  <= part_next;
      carry_q <= cout;
      zacc_q  <= zero_all;
      if (last) begin
        result_o <= (ctl_q.is_eq || ctl_q.is_gt) ? {{(DATA_W-1){1'b0}}, cmp_bit}
                                                  : part_next;
        c_o <= cout;
        z_o <= zero_all;
        v_o <= v_fin;
        n_o <= part_next[DATA_W-1];
      end
    end
  end
endmodule

// File: rtl/bsa_checker.sv
module bsa_checker
  import bsa_pkg::*;
#(
  parameter  int BYTE_W    = 8,
  parameter  int NUM_BYTES = 2,
  localparam int DATA_W    = BYTE_W * NUM_BYTES,
  localparam int CNT_W     = (NUM_BYTES > 1) ? $clog2(NUM_BYTES) : 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o,
  input logic              c_o,
  input logic              z_o,
  input logic              v_o,
  input logic              n_o
);
  timeunit 1ns;
  timeprecision 1ps;

  logic             inflight, exp_done;
  logic [CNT_W-1:0] age;
  logic [OP_W-1:0]  op_lat;
  logic             is_cmp, is_logic;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inflight <= 1'b0;
      exp_done <= 1'b0;
      age      <= '0;
      op_lat   <= '0;
    end else begin
      exp_done <= 1'b0;
      if (inflight) begin
        if (age == CNT_W'(NUM_BYTES - 1)) begin
          inflight <= 1'b0;
          exp_done <= 1'b1;
        end else begin
          age <= age + 1'b1;
        end
      end else if (start_i) begin
        inflight <= 1'b1;
        age      <= '0;
        op_lat   <= op_i;
      end
    end
  end

  assign is_cmp   = (op_lat == OP_EQ) || (op_lat == OP_SGT);
  assign is_logic = (op_lat == OP_AND) || (op_lat == OP_OR) || (op_lat == OP_XOR);

  p_done_timing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o == exp_done);

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable({c_o, z_o, v_o, n_o})));

  if (NUM_BYTES > 1) begin : g_pulse
    p_done_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o);
  end

  p_logic_flags_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && is_logic) |-> (!c_o && !v_o));

  p_shr_top_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_lat == OP_SHR) |-> (!result_o[DATA_W-1] && !v_o));

  p_zn_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !is_cmp) |-> ((z_o == (result_o == '0)) && (n_o == result_o[DATA_W-1])));

  p_eq_bit_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_lat == OP_EQ) |-> (result_o == {{(DATA_W-1){1'b0}}, z_o}));

  p_gt_bit_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_lat == OP_SGT) |-> (result_o == {{(DATA_W-1){1'b0}}, n_o ^ v_o}));
endmodule

bind byte_seq_alu bsa_checker #(
  .BYTE_W   (BYTE_W),
  .NUM_BYTES(NUM_BYTES)
) i_bsa_checker (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .op_i    (op_i),
  .result_o(result_o),
  .done_o  (done_o),
  .c_o     (c_o),
  .z_o     (z_o),
  .v_o     (v_o),
  .n_o     (n_o)
);

// File: tb/test_byte_seq_alu.sv
module test_byte_seq_alu;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_s = 1'b0;
  logic [3:0]  op_s = '0;
  logic [15:0] a_s = '0, b_s = '0;
  logic [15:0] result_o;
  logic        done_o, c_o, z_o, v_o, n_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  bit          m_busy = 0, m_done = 0, ign = 0;
  int          m_cnt = 0, m_op = 0;
  logic [15:0] m_a = '0, m_b = '0;
  logic [15:0] e_res = '0;
  logic        e_c = 0, e_z = 0, e_v = 0, e_n = 0;
  string       e_tag = "R2", zn_tag = "R2";
  logic [31:0] rng = 32'h1357_9bdf;

  always #2 clk = ~clk;

  byte_seq_alu i_byte_seq_alu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_s), .op_i(op_s),
    .a_i(a_s), .b_i(b_s), .result_o(result_o), .done_o(done_o),
    .c_o(c_o), .z_o(z_o), .v_o(v_o), .n_o(n_o)
  );

  function automatic string tag_of(input int o);
    case (o)
      0: return "R3";
      1: return "R4";
      2, 3: return "R5";
      4, 5, 6: return "R6";
      7: return "R7";
      8: return "R8";
      9: return "R9";
      10: return "R11";
      11: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic ref_op(input int o, input logic [15:0] x, input logic [15:0] y,
                        output logic [15:0] r, output logic c, output logic z,
                        output logic v, output logic n);
    logic [16:0] s;
    logic [15:0] d;
    bit cmp;
    cmp = 0; z = 0; n = 0;
    case (o)
      1, 3: begin
        d = (o == 3) ? 16'd1 : y;
        r = x - d; c = (x >= d);
        v = (x[15] != d[15]) && (r[15] != x[15]);
      end
      4: begin r = x & y; c = 0; v = 0; end
      5: begin r = x | y; c = 0; v = 0; end
      6: begin r = x ^ y; c = 0; v = 0; end
      7: begin r = {x[14:0], 1'b0}; c = x[15]; v = x[15] ^ x[14]; end
      8: begin r = {1'b0, x[15:1]}; c = x[0]; v = 0; end
      9: begin r = {x[15], x[15:1]}; c = x[0]; v = 0; end
      10: begin
        d = x - y; c = (x >= y); v = (x[15] != y[15]) && (d[15] != x[15]);
        z = (d == 0); n = d[15]; r = {15'b0, x == y}; cmp = 1;
      end
      11: begin
        d = y - x; c = (y >= x); v = (y[15] != x[15]) && (d[15] != y[15]);
        z = (d == 0); n = d[15]; r = {15'b0, $signed(x) > $signed(y)}; cmp = 1;
      end
      default: begin  // add, inc, reserved
        d = (o == 2) ? 16'd1 : y;
        s = {1'b0, x} + {1'b0, d};
        r = s[15:0]; c = s[16];
        v = (x[15] == d[15]) && (r[15] != x[15]);
      end
    endcase
    if (!cmp) begin z = (r == 0); n = r[15]; end
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    m_done = 0;
    if (m_busy) begin
      m_cnt++;
      if (m_cnt == 2) begin
        m_busy = 0; m_done = 1;
        ref_op(m_op, m_a, m_b, e_res, e_c, e_z, e_v, e_n);
        e_tag  = ign ? "R1" : tag_of(m_op);
        zn_tag = ign ? "R1" : ((m_op == 10 || m_op == 11) ? e_tag : "R10");
      end
    end else if (start_s) begin
      m_busy = 1; m_cnt = 0; m_op = int'(op_s); m_a = a_s; m_b = b_s;
    end
    #1;
    chk("R2", "done", 32'(done_o), 32'(m_done));
    chk(e_tag, "result", 32'(result_o), 32'(e_res));
    chk(e_tag, "C", 32'(c_o), 32'(e_c));
    chk(e_tag, "V", 32'(v_o), 32'(e_v));
    chk(zn_tag, "Z", 32'(z_o), 32'(e_z));
    chk(zn_tag, "N", 32'(n_o), 32'(e_n));
  endtask

  task automatic issue(input int o, input logic [15:0] x, input logic [15:0] y);
    start_s = 1; op_s = o[3:0]; a_s = x; b_s = y;
    step();
    start_s = 0;
    step();
    step();
  endtask

  task automatic rnd16(output logic [15:0] r);
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    r = rng[15:0];
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  localparam logic [15:0] CORNER [12] = '{
    16'h0000, 16'h0001, 16'h007F, 16'h0080, 16'h00FF, 16'h0100,
    16'h34F0, 16'h2240, 16'h7FFF, 16'h8000, 16'hFFFF, 16'hC428
  };

  initial begin
    logic [15:0] x, y, s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R2: reset state
    chk("R2", "reset result", 32'(result_o), 32'h0);
    chk("R2", "reset done", 32'(done_o), 32'h0);
    chk("R2", "reset flags", 32'({c_o, z_o, v_o, n_o}), 32'h0);

    // directed corners, all codes (R3..R13)
    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 12; i++) begin
        issue(o, CORNER[i], CORNER[(i + 5) % 12]);
        issue(o, CORNER[i], CORNER[i]);
      end
    end

    // R1: strobe held high with other operands while busy
    for (int k = 0; k < 6; k++) begin
      rnd16(x); rnd16(y);
      ign = 1;
      start_s = 1; op_s = 4'(k); a_s = x; b_s = y;
      step();
      op_s = 4'(k + 6); a_s = ~x; b_s = y ^ 16'h5A5A;
      step();
      step();
      start_s = 0;
      ign = 0;
      step();
    end

    // random operands and codes, with idle gaps
    for (int k = 0; k < 500; k++) begin
      rnd16(x); rnd16(y); rnd16(s);
      issue(int'(s[3:0]), x, y);
      if (s[4]) step();
    end

    repeat (2) step();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule